// File: doc/BRIEF.md
# Banked User Nonvolatile ROM Port

This block models a small user nonvolatile store of 1,024 bits, held as registers. The store is split into eight banks of 128 bits. A programming-side port is the only writer, and it replaces one whole bank per operation. Core logic cannot write. It reads one byte at a time through a registered read port. The programming side can also see the committed contents of any bank through a combinational readback bus.

A bank update is a fixed four-step state machine. IDLE leaves for ERASE_A when a write strobe arrives while the block is not busy. From there the machine always steps ERASE_A -> ERASE_B -> PROG_A -> PROG_B -> IDLE. The new bank value is committed on the edge that leaves PROG_B. Busy is high in every state except IDLE. The store itself changes only at commit, so any core read taken while an update is in flight sees the previous contents.

Top module: `nvrom_bank_port`

## Requirements
- R1: The 7-bit read address is decoded with bits [6:4] as the bank number (0 to 7) and bits [3:0] as the byte within that bank (0 to 15).
- R2: Byte 0 of a bank is bits [7:0] of the 128-bit bank word, and byte 15 is bits [127:120].
- R3: When `rd_en` is high at a rising edge, `rd_data` shows the addressed byte from the next cycle on. In any cycle where `rd_en` was low at the previous edge, `rd_data` keeps its value.
- R4: After reset every bit of every bank reads as 1, and `rd_data` is 8'hFF.
- R5: A high `pg_wr` at an edge where `busy` is low is accepted. `busy` is high from the next cycle for exactly 4 cycles and then falls.
- R6: A core read strobed while `busy` is high returns the bank's old contents. A read strobed once `busy` has fallen returns the written data.
- R7: A `pg_wr` pulse while `busy` is high is ignored. No bank takes its data, and the busy window is not extended.
- R8: `pg_rdata` always shows the committed 128-bit word of the bank selected by `pg_bank`.
- R9: A bank write changes only the selected bank. All other banks keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, returns the store to the erased state |
| rd_en | input | 1 | Core read strobe |
| rd_addr | input | 7 | Core byte address, {bank, byte} |
| rd_data | output | 8 | Registered read byte |
| pg_bank | input | 3 | Programming-side bank select, used for both write and readback |
| pg_data | input | 128 | Programming-side bank word to write |
| pg_wr | input | 1 | Programming-side write strobe |
| busy | output | 1 | High while a bank update is in progress |
| pg_rdata | output | 128 | Committed word of bank `pg_bank` |

## Verification
The bench writes each bank with its own pattern, in which every byte differs from its neighbours and from the same byte of other banks. Any error in the bank or byte decode, or a reversed byte order, therefore returns a wrong value. Reads run in several orders: the first and last byte of every bank, a full sweep of one bank, and back-to-back strobes followed by idle cycles. These separate the data path from the read-hold behaviour. Reads taken in the middle of an update, and a second write strobe during busy, separate commit-at-end from early or repeated commits. Readback of untouched banks shows whether a write leaks into other banks.

// File: rtl/nvrom_pkg.sv
package nvrom_pkg;
    parameter int NUM_BANKS  = 8;
    parameter int BANK_BITS  = 128;
    parameter int BYTE_W     = 8;

    localparam int BYTES_PER_BANK = BANK_BITS / BYTE_W;
    localparam int BANK_SEL_W     = $clog2(NUM_BANKS);
    localparam int BYTE_SEL_W     = $clog2(BYTES_PER_BANK);
    localparam int ADDR_W         = BANK_SEL_W + BYTE_SEL_W;
    localparam int BIT_IDX_W      = $clog2(BANK_BITS);
    localparam int LANE_SHIFT_W   = $clog2(BYTE_W);
    localparam int WRITE_CYCLES   = 4;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ERASE_A = 3'd1,
        ST_ERASE_B = 3'd2,
        ST_PROG_A  = 3'd3,
        ST_PROG_B  = 3'd4
    } upd_state_t;

    typedef logic [BANK_BITS-1:0]  bank_word_t;
    typedef logic [BANK_SEL_W-1:0] bank_sel_t;
endpackage

// File: rtl/nvrom_upd_fsm.sv
module nvrom_upd_fsm
    import nvrom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req,
    input  bank_sel_t  wr_bank_in,
    input  bank_word_t wr_data_in,
    output logic       busy,
    output logic       commit,
    output bank_sel_t  commit_bank,
    output bank_word_t commit_data
);
    upd_state_t state_q, state_d;
    logic       accept;

    assign accept = (state_q == ST_IDLE) && wr_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (wr_req) state_d = ST_ERASE_A;
            ST_ERASE_A: state_d = ST_ERASE_B;
            ST_ERASE_B: state_d = ST_PROG_A;
            ST_PROG_A:  state_d = ST_PROG_B;
            ST_PROG_B:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            commit_bank <= '0;
            commit_data <= '1;
        end else begin
            state_q <= state_d;
            if (accept) begin
                commit_bank <= wr_bank_in;
                commit_data <= wr_data_in;
            end
        end
    end

    always_comb begin
        busy   = 1'b1;
        commit = 1'b0;
        unique case (state_q)
            ST_IDLE:    busy = 1'b0;
            ST_ERASE_A,
            ST_ERASE_B,
            ST_PROG_A:  busy = 1'b1;
            ST_PROG_B:  commit = 1'b1;
            default:    busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/nvrom_store.sv
module nvrom_store
    import nvrom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  bank_sel_t         commit_bank,
    input  bank_word_t        commit_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  bank_sel_t         pg_bank,
    output bank_word_t        pg_rdata
);
    bank_word_t                bank_q [NUM_BANKS];
    bank_sel_t                 rd_bank;
    logic [BYTE_SEL_W-1:0]     rd_byte;
    logic [BIT_IDX_W-1:0]      rd_lsb;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank_q[b] <= '1;
            else if (commit && (commit_bank == bank_sel_t'(b)))
                bank_q[b] <= commit_data;
        end
    end

    assign rd_bank = rd_addr[ADDR_W-1:BYTE_SEL_W];
    assign rd_byte = rd_addr[BYTE_SEL_W-1:0];
    assign rd_lsb  = {rd_byte, {LANE_SHIFT_W{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data <= '1;
        else if (rd_en)
            rd_data <= bank_q[rd_bank][rd_lsb +: BYTE_W];
    end

    assign pg_rdata = bank_q[pg_bank];
endmodule

// File: rtl/nvrom_bank_port.sv
module nvrom_bank_port
    import nvrom_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [BYTE_W-1:0]    rd_data,
    input  logic [BANK_SEL_W-1:0] pg_bank,
    input  logic [BANK_BITS-1:0] pg_data,
    input  logic                 pg_wr,
    output logic                 busy,
    output logic [BANK_BITS-1:0] pg_rdata
);
    logic       commit;
    bank_sel_t  commit_bank;
    bank_word_t commit_data;

    nvrom_upd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_req      (pg_wr),
        .wr_bank_in  (pg_bank),
        .wr_data_in  (pg_data),
        .busy        (busy),
        .commit      (commit),
        .commit_bank (commit_bank),
        .commit_data (commit_data)
    );

    nvrom_store u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_bank (commit_bank),
        .commit_data (commit_data),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .pg_bank     (pg_bank),
        .pg_rdata    (pg_rdata)
    );
endmodule

// File: rtl/nvrom_bank_port_chk.sv
module nvrom_bank_port_chk
    import nvrom_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [BYTE_W-1:0] rd_data,
    input logic              pg_wr,
    input logic              busy
);
    logic [2:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_cnt <= '0;
        else if (busy)
            busy_cnt <= busy_cnt + 3'd1;
        else
            busy_cnt <= '0;
    end

    assert_read_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_write_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && pg_wr) |=> busy);

    assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < 3'(WRITE_CYCLES)));

    assert_no_extend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_cnt == 3'(WRITE_CYCLES - 1)) |=> !busy);
endmodule

bind nvrom_bank_port nvrom_bank_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pg_wr   (pg_wr),
    .busy    (busy)
);

// File: tb/nvrom_bank_port_test.sv
module nvrom_bank_port_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_en = 1'b0;
    logic [6:0]   rd_addr = '0;
    logic [7:0]   rd_data;
    logic [2:0]   pg_bank = '0;
    logic [127:0] pg_data = '0;
    logic         pg_wr = 1'b0;
    logic         busy;
    logic [127:0] pg_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    logic [127:0] model [8];

    always #2.5 clk = ~clk;

    nvrom_bank_port uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .pg_bank(pg_bank), .pg_data(pg_data), .pg_wr(pg_wr), .busy(busy), .pg_rdata(pg_rdata)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] pattern(input logic [7:0] seed);
        logic [127:0] w;
        for (int i = 0; i < 16; i++) w[i*8 +: 8] = seed ^ 8'(i * 29 + 3);
        return w;
    endfunction

    // one read: strobe at an edge, sample at the following falling edge
    task automatic do_read(input logic [6:0] a, output logic [7:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic read_expect(input string req, input logic [2:0] b, input logic [3:0] by);
        logic [7:0] v;
        do_read({b, by}, v);
        check(req, 128'(v), 128'(model[b][by*8 +: 8]));
    endtask

    task automatic write_bank(input logic [2:0] b, input logic [127:0] d);
        pg_bank = b; pg_data = d; pg_wr = 1'b1;
        @(negedge clk);
        pg_wr = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check("R5 busy high", 128'(busy), 128'(1));
            @(negedge clk);
        end
        check("R5 busy falls", 128'(busy), 128'(0));
        model[b] = d;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int b = 0; b < 8; b++) model[b] = '1;
        check("R4 busy at reset", 128'(busy), 128'(0));
        check("R4 rd_data at reset", 128'(rd_data), 128'(8'hFF));
        do_read(7'h5A, v);
        check("R4 erased byte", 128'(v), 128'(8'hFF));
        pg_bank = 3'd6; #1;
        check("R4 R8 erased readback", pg_rdata, '1);
    endtask

    task automatic t_fill_and_decode;
        for (int b = 0; b < 8; b++) write_bank(3'(b), pattern(8'(b * 37 + 5)));
        for (int b = 0; b < 8; b++) begin
            read_expect("R1 R2 byte0", 3'(b), 4'd0);
            read_expect("R1 R2 byte15", 3'(b), 4'd15);
        end
        for (int i = 0; i < 16; i++) read_expect("R1 sweep bank3", 3'd3, 4'(i));
        for (int b = 0; b < 8; b++) begin
            pg_bank = 3'(b); #1;
            check("R8 readback", pg_rdata, model[b]);
        end
    endtask

    task automatic t_read_hold;
        logic [7:0] v;
        do_read({3'd2, 4'd9}, v);
        for (int k = 0; k < 3; k++) begin
            rd_addr = 7'(k * 11);
            @(negedge clk);
            check("R3 hold without strobe", 128'(rd_data), 128'(model[2][9*8 +: 8]));
        end
    endtask

    task automatic t_read_during_write;
        logic [127:0] old5, nw;
        logic [7:0] v;
        old5 = model[5];
        nw = pattern(8'hC3);
        pg_bank = 3'd5; pg_data = nw; pg_wr = 1'b1;
        @(negedge clk);
        pg_wr = 1'b0;
        for (int k = 0; k < 4; k++) begin
            do_read({3'd5, 4'(k + 4)}, v);
            check("R6 old data while busy", 128'(v), 128'(old5[(k + 4)*8 +: 8]));
        end
        check("R6 busy done", 128'(busy), 128'(0));
        model[5] = nw;
        read_expect("R6 new data after busy", 3'd5, 4'd4);
        read_expect("R6 new data after busy", 3'd5, 4'd15);
        for (int b = 0; b < 8; b++) begin
            pg_bank = 3'(b); #1;
            check("R9 other banks intact", pg_rdata, model[b]);
        end
    endtask

    task automatic t_write_while_busy;
        pg_bank = 3'd1; pg_data = pattern(8'h11); pg_wr = 1'b1;
        @(negedge clk);
        pg_wr = 1'b0;
        @(negedge clk);
        pg_bank = 3'd7; pg_data = pattern(8'h77); pg_wr = 1'b1;
        @(negedge clk);
        pg_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R7 busy not extended", 128'(busy), 128'(0));
        model[1] = pattern(8'h11);
        pg_bank = 3'd7; #1;
        check("R7 ignored write left bank7", pg_rdata, model[7]);
        read_expect("R7 bank7 byte", 3'd7, 4'd8);
        read_expect("R5 bank1 written", 3'd1, 4'd2);
    endtask

    initial begin
        #10000;
        n_checks++; n_fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_and_decode();
        t_read_hold();
        t_read_during_write();
        t_write_while_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule